// File: doc/BRIEF.md
# Configuration Image Loader with Sum Check

This block keeps a local copy of a 64-word configuration store that lives in an external serial memory. It sits above a word-access master that handles the serial pins. It offers a lookup port on the core side: an index goes in and one 16-bit word comes back. The image is loaded lazily. When a lookup arrives and the cached image is not marked good, the block first reads every word from the store in ascending order. It then checks the wrapped 16-bit sum of the words against a fixed target, and checks a two-bit signature field inside one designated control word. Only then does it answer.

A checksum-repair command reads the leading 63 words and writes the missing amount into the last word, so that the whole image sums to the target. Writing a word always clears the cached signature word. As a result, the next lookup reloads the image from the store.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, `ready` is 1, `img_valid` is 0, and both `ee_req` and `lk_resp` are 0.
- R2: A load reads addresses 0 to 63 in ascending order. Each transfer ends in a cycle where `ee_req` and `ee_done` are both 1. While `ee_req` is 1 and `ee_done` is 0, `ee_addr` and `ee_wr` hold their values.
- R3: After a load, `img_valid` is 1 only when two conditions both hold. First, the 16-bit sum of all 64 words, wrapping modulo 2^16, equals 0xBABA. Second, bits [15:14] of word 10 equal 2'b01.
- R4: When the sum does not match, the cached word 10 is set to 0x0000. `img_valid` is then 0, and the lookup returns 0.
- R5: When the sum matches but bits [15:14] of word 10 are not 2'b01, `img_valid` is 0 and the lookup returns 0.
- R6: A lookup accepted while `img_valid` is 1 with an index below 64 is answered from the cache with no memory transfer. `lk_resp` pulses for one cycle, in the cycle after acceptance, and `lk_word` carries the word at that index.
- R7: A lookup accepted while `img_valid` is 0 with an index below 64 runs a full 64-word load before it is answered. A lookup that follows a failed load reloads again.
- R8: A lookup with an index of 64 or more returns 0 and causes no memory transfer, whether or not the image is valid.
- R9: A command is accepted only in a cycle with `ready` at 1. `ready` is 0 during a load or a repair. If `csum_fix` and `lk_req` are both 1 in the same accepting cycle, the repair is taken and the lookup is dropped.
- R10: A repair reads words 0 to 62. It then makes one write (`ee_wr` = 1) to address 63 with the value 0xBABA minus the wrapped sum of those 63 words.
- R11: When that write completes, `img_valid` drops to 0, and the next lookup within range reloads the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request, taken when ready is 1 |
| lk_idx | input | 7 | Lookup word index, 0 to 127 |
| csum_fix | input | 1 | Checksum repair command, taken when ready is 1 |
| ready | output | 1 | Block idle and able to take a command |
| lk_resp | output | 1 | One-cycle pulse marking a lookup answer |
| lk_word | output | 16 | Lookup answer, valid while lk_resp is 1 |
| img_valid | output | 1 | Cached image passed the sum and signature tests |
| ee_req | output | 1 | Word transfer request to the memory master |
| ee_wr | output | 1 | 1 for a write transfer, 0 for a read |
| ee_addr | output | 6 | Word address of the transfer |
| ee_wdata | output | 16 | Write data |
| ee_rdata | input | 16 | Read data, valid with ee_done |
| ee_done | input | 1 | Transfer complete for one cycle |

## Verification
The bench uses the default parameters: 64 words of 16 bits, a target of 0xBABA, the signature in word 10 under mask 0xC000 with pattern 0x4000, and a clear value of 0x0000. With these values, the image sums wrap many times, and the out-of-range indices 64 to 127 can be reached through the 7-bit index. A memory model with a two-cycle answer latency places back-to-back transfers on the port. This tests the address-hold rule and the ascending load order. The bench also builds images that fail only the sum test or only the signature test.

// File: rtl/cil_pkg.sv
package cil_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CHECK,
    ST_RESP,
    ST_FIX_RD,
    ST_FIX_WR
  } cil_state_e;
endpackage

// File: rtl/cil_accum.sv
module cil_accum #(
  parameter int unsigned      DW         = 16,
  parameter logic [DW-1:0]    SUM_TARGET = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] din,
  output logic          match,
  output logic [DW-1:0] remainder
);
  logic [DW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)      sum_d = '0;
    else if (add) sum_d = sum_q + din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sum_q <= '0;
    else if (clr || add) sum_q <= sum_d;
  end

  assign match     = (sum_q == SUM_TARGET);
  assign remainder = SUM_TARGET - sum_q;
endmodule

// File: rtl/cil_shadow.sv
module cil_shadow #(
  parameter int unsigned   WORDS     = 64,
  parameter int unsigned   DW        = 16,
  parameter int unsigned   AW        = 6,
  parameter int unsigned   SIG_IDX   = 10,
  parameter logic [DW-1:0] SIG_MASK  = 16'hC000,
  parameter logic [DW-1:0] SIG_VALID = 16'h4000,
  parameter logic [DW-1:0] SIG_CLEAR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          sig_clr,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          sig_ok
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit      = wr_en && (wr_idx == AW'(g));
    assign words[g] = q;
    if (g == SIG_IDX) begin : g_sig
      // The signature word carries the validity state, so it is the only word with a reset.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= SIG_CLEAR;
        else if (sig_clr) q <= SIG_CLEAR;
        else if (hit)     q <= wr_data;
      end
    end else begin : g_data
      always_ff @(posedge clk) begin
        if (hit) q <= wr_data;
      end
    end
  end

  assign rd_data = words[rd_idx];
  assign sig_ok  = (words[SIG_IDX] & SIG_MASK) == SIG_VALID;

  // R4
  sig_clear_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clr |=> !sig_ok);
endmodule

// File: rtl/cil_seq.sv
module cil_seq
  import cil_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 6,
  parameter int unsigned IW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_req,
  input  logic [IW-1:0] lk_idx,
  input  logic          csum_fix,
  input  logic          ee_done,
  input  logic          sig_ok,
  input  logic          sum_match,
  input  logic [DW-1:0] shadow_word,
  output logic          ready,
  output logic          lk_resp,
  output logic [DW-1:0] lk_word,
  output logic          ee_req,
  output logic          ee_wr,
  output logic [AW-1:0] ee_addr,
  output logic          acc_clr,
  output logic          acc_add,
  output logic          sh_wr,
  output logic          sig_clr,
  output logic [AW-1:0] rd_idx
);
  localparam logic [AW-1:0] LAST   = AW'(WORDS - 1);
  localparam logic [AW-1:0] FIXEND = AW'(WORDS - 2);
  localparam logic [IW-1:0] LIMIT  = IW'(WORDS);

  cil_state_e    state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] word_q, word_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    word_d  = word_q;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    sh_wr   = 1'b0;
    sig_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (csum_fix) begin
          cnt_d   = '0;
          acc_clr = 1'b1;
          state_d = ST_FIX_RD;
        end else if (lk_req) begin
          idx_d = lk_idx;
          if (lk_idx >= LIMIT) begin
            word_d  = '0;
            state_d = ST_RESP;
          end else if (sig_ok) begin
            word_d  = shadow_word;
            state_d = ST_RESP;
          end else begin
            cnt_d   = '0;
            acc_clr = 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (ee_done) begin
          sh_wr   = 1'b1;
          acc_add = 1'b1;
          if (cnt_q == LAST) state_d = ST_CHECK;
          else               cnt_d   = cnt_q + AW'(1);
        end
      end
      ST_CHECK: begin
        sig_clr = !sum_match;
        word_d  = (sum_match && sig_ok) ? shadow_word : '0;
        state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      ST_FIX_RD: begin
        if (ee_done) begin
          acc_add = 1'b1;
          cnt_d   = cnt_q + AW'(1);
          if (cnt_q == FIXEND) state_d = ST_FIX_WR;
        end
      end
      ST_FIX_WR: begin
        if (ee_done) begin
          sig_clr = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_IDLE) idx_q <= idx_d;
      if (state_q == ST_IDLE || state_q == ST_CHECK) word_q <= word_d;
    end
  end

  assign ready   = (state_q == ST_IDLE);
  assign lk_resp = (state_q == ST_RESP);
  assign lk_word = word_q;
  assign ee_req  = (state_q == ST_LOAD) || (state_q == ST_FIX_RD) || (state_q == ST_FIX_WR);
  assign ee_wr   = (state_q == ST_FIX_WR);
  assign ee_addr = cnt_q;
  assign rd_idx  = (state_q == ST_IDLE) ? lk_idx[AW-1:0] : idx_q[AW-1:0];

  // R2
  load_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) && ee_done && (cnt_q != LAST) |=> ee_addr == $past(ee_addr) + AW'(1));
  // R8
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_resp && (idx_q >= LIMIT) |-> lk_word == '0);
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int unsigned   WORDS      = 64,
  parameter int unsigned   DW         = 16,
  parameter int unsigned   SIG_IDX    = 10,
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
  parameter logic [DW-1:0] SIG_VALID  = 16'h4000,
  parameter logic [DW-1:0] SIG_CLEAR  = 16'h0000,
  localparam int unsigned  AW         = $clog2(WORDS),
  localparam int unsigned  IW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_req,
  input  logic [IW-1:0] lk_idx,
  input  logic          csum_fix,
  output logic          ready,
  output logic          lk_resp,
  output logic [DW-1:0] lk_word,
  output logic          img_valid,
  output logic          ee_req,
  output logic          ee_wr,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_wdata,
  input  logic [DW-1:0] ee_rdata,
  input  logic          ee_done
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          acc_clr, acc_add, sh_wr, sig_clr, sig_ok, sum_match;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] shadow_word;

  cil_seq #(.WORDS(WORDS), .DW(DW), .AW(AW), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_ni),
    .lk_req      (lk_req),
    .lk_idx      (lk_idx),
    .csum_fix    (csum_fix),
    .ee_done     (ee_done),
    .sig_ok      (sig_ok),
    .sum_match   (sum_match),
    .shadow_word (shadow_word),
    .ready       (ready),
    .lk_resp     (lk_resp),
    .lk_word     (lk_word),
    .ee_req      (ee_req),
    .ee_wr       (ee_wr),
    .ee_addr     (ee_addr),
    .acc_clr     (acc_clr),
    .acc_add     (acc_add),
    .sh_wr       (sh_wr),
    .sig_clr     (sig_clr),
    .rd_idx      (rd_idx)
  );

  cil_accum #(.DW(DW), .SUM_TARGET(SUM_TARGET)) u_accum (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (acc_clr),
    .add       (acc_add),
    .din       (ee_rdata),
    .match     (sum_match),
    .remainder (ee_wdata)
  );

  cil_shadow #(
    .WORDS(WORDS), .DW(DW), .AW(AW), .SIG_IDX(SIG_IDX),
    .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID), .SIG_CLEAR(SIG_CLEAR)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (sh_wr),
    .wr_idx  (ee_addr),
    .wr_data (ee_rdata),
    .sig_clr (sig_clr),
    .rd_idx  (rd_idx),
    .rd_data (shadow_word),
    .sig_ok  (sig_ok)
  );

  assign img_valid = sig_ok;

  // R2
  ee_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ee_req && !ee_done |=> ee_req && $stable(ee_addr) && $stable(ee_wr));
  // R10
  fix_write_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ee_req && ee_wr |-> ee_addr == AW'(WORDS - 1));
  // R6
  cached_fast_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ready && lk_req && !csum_fix && img_valid && (lk_idx < IW'(WORDS)) |=> lk_resp && !ee_req);
  // R5
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_resp && !img_valid |-> lk_word == '0);
endmodule

// File: tb/test_cfg_image_loader.sv
module test_cfg_image_loader;
  localparam int W = 64;
  localparam logic [15:0] TGT = 16'hBABA;
  localparam int SIGI = 10;
  localparam int LAT = 2;

  logic        clk, rst_n;
  logic        lk_req, csum_fix;
  logic [6:0]  lk_idx;
  logic        ready, lk_resp, img_valid, ee_req, ee_wr, ee_done;
  logic [15:0] lk_word, ee_wdata, ee_rdata;
  logic [5:0]  ee_addr;

  cfg_image_loader i_cfg_image_loader (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_idx(lk_idx), .csum_fix(csum_fix),
    .ready(ready), .lk_resp(lk_resp), .lk_word(lk_word), .img_valid(img_valid),
    .ee_req(ee_req), .ee_wr(ee_wr), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .ee_done(ee_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model
  logic [15:0] smem [W];
  logic        poke_en;
  logic [5:0]  poke_a;
  logic [15:0] poke_d;
  int          mcnt, rd_cnt, wr_cnt, ord_err, resp_cnt;
  int          prev_a;
  logic [5:0]  last_wa;
  logic [15:0] last_wd;

  always @(posedge clk) begin
    if (poke_en) smem[poke_a] <= poke_d;
    if (lk_resp) resp_cnt <= resp_cnt + 1;
    if (!rst_n) begin
      ee_done <= 1'b0;
      mcnt    <= 0;
      prev_a  <= -1;
    end else if (ee_done) begin
      ee_done <= 1'b0;
      mcnt    <= 0;
    end else if (ee_req) begin
      if (mcnt == LAT) begin
        ee_done <= 1'b1;
        if (ee_wr) begin
          smem[ee_addr] <= ee_wdata;
          wr_cnt  <= wr_cnt + 1;
          last_wa <= ee_addr;
          last_wd <= ee_wdata;
        end else begin
          ee_rdata <= smem[ee_addr];
          rd_cnt   <= rd_cnt + 1;
          if (!(int'(ee_addr) == 0 || int'(ee_addr) == prev_a + 1)) ord_err <= ord_err + 1;
          prev_a <= int'(ee_addr);
        end
      end else mcnt <= mcnt + 1;
    end
  end

  int checks, fails;
  logic [15:0] img [W];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic build_image(input int seed, input logic [1:0] sig_top, input bit bad_sum);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < W - 1; i++) begin
      img[i] = 16'(i * 16'h3B1D + seed * 16'h0F0F + 16'h1234) ^ 16'(i << 9);
      if (i == SIGI) img[i] = {sig_top, img[i][13:0]};
      s = s + img[i];
    end
    img[W-1] = TGT - s;
    if (bad_sum) img[7] = img[7] + 16'h0001;
    @(negedge clk);
    poke_en = 1'b1;
    for (int i = 0; i < W; i++) begin
      poke_a = 6'(i);
      poke_d = img[i];
      @(negedge clk);
    end
    poke_en = 1'b0;
  endtask

  task automatic lookup(input int idx, input logic [15:0] exp, input int exp_reads,
                        input bit fast, input string req);
    int r0, o0, n;
    r0 = rd_cnt; o0 = ord_err; n = 0;
    while (!ready) @(negedge clk);
    lk_req = 1'b1;
    lk_idx = 7'(idx);
    @(negedge clk);
    lk_req = 1'b0;
    if (fast) chk(lk_resp == 1'b1, req, "answer one cycle after accept", int'(lk_resp), 1);
    while (!lk_resp && n < 3000) begin @(negedge clk); n++; end
    chk(lk_word == exp, req, $sformatf("word at index %0d", idx), int'(lk_word), int'(exp));
    chk(rd_cnt - r0 == exp_reads, req, "read transfers", rd_cnt - r0, exp_reads);
    chk(ord_err == o0, "R2", "ascending load order", ord_err - o0, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1", "ready", int'(ready), 1);
    chk(img_valid == 1'b0, "R1", "img_valid", int'(img_valid), 0);
    chk(ee_req == 1'b0, "R1", "ee_req", int'(ee_req), 0);
    chk(lk_resp == 1'b0, "R1", "lk_resp", int'(lk_resp), 0);
  endtask

  task automatic t_first_load();
    build_image(1, 2'b01, 1'b0);
    lookup(3, img[3], W, 1'b0, "R7");
    chk(img_valid == 1'b1, "R3", "valid after good load", int'(img_valid), 1);
  endtask

  task automatic t_cached();
    lookup(20, img[20], 0, 1'b1, "R6");
    lookup(SIGI, img[SIGI], 0, 1'b1, "R6");
  endtask

  task automatic t_out_of_range(input string req);
    lookup(64, 16'h0, 0, 1'b1, req);
    lookup(127, 16'h0, 0, 1'b1, req);
  endtask

  task automatic t_fix();
    int r0, w0, n;
    logic [15:0] s, expw;
    img[5] = img[5] ^ 16'h5A5A;
    @(negedge clk);
    poke_en = 1'b1; poke_a = 6'd5; poke_d = img[5];
    @(negedge clk);
    poke_en = 1'b0;
    s = '0;
    for (int i = 0; i < W - 1; i++) s = s + img[i];
    expw = TGT - s;
    r0 = rd_cnt; w0 = wr_cnt; n = 0;
    csum_fix = 1'b1;
    @(negedge clk);
    csum_fix = 1'b0;
    chk(ready == 1'b0, "R9", "busy during repair", int'(ready), 0);
    while (!ready && n < 3000) begin @(negedge clk); n++; end
    chk(rd_cnt - r0 == W - 1, "R10", "repair reads", rd_cnt - r0, W - 1);
    chk(wr_cnt - w0 == 1, "R10", "repair writes", wr_cnt - w0, 1);
    chk(last_wa == 6'(W - 1), "R10", "write address", int'(last_wa), W - 1);
    chk(last_wd == expw, "R10", "write value", int'(last_wd), int'(expw));
    chk(img_valid == 1'b0, "R11", "invalid after write", int'(img_valid), 0);
    img[W-1] = expw;
    lookup(5, img[5], W, 1'b0, "R11");
    chk(img_valid == 1'b1, "R11", "valid after reload", int'(img_valid), 1);
  endtask

  task automatic t_bad_sum();
    do_reset();
    build_image(2, 2'b01, 1'b1);
    lookup(SIGI, 16'h0, W, 1'b0, "R4");
    chk(img_valid == 1'b0, "R4", "invalid on sum mismatch", int'(img_valid), 0);
    lookup(2, 16'h0, W, 1'b0, "R7");
  endtask

  task automatic t_bad_sig();
    do_reset();
    build_image(3, 2'b10, 1'b0);
    lookup(4, 16'h0, W, 1'b0, "R5");
    chk(img_valid == 1'b0, "R5", "invalid on signature", int'(img_valid), 0);
    lookup(70, 16'h0, 0, 1'b1, "R8");
  endtask

  task automatic t_priority();
    int w0, p0, n;
    w0 = wr_cnt; p0 = resp_cnt; n = 0;
    while (!ready) @(negedge clk);
    csum_fix = 1'b1; lk_req = 1'b1; lk_idx = 7'd1;
    @(negedge clk);
    csum_fix = 1'b0; lk_req = 1'b0;
    while (!ready && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(wr_cnt - w0 == 1, "R9", "repair taken over lookup", wr_cnt - w0, 1);
    chk(resp_cnt == p0, "R9", "dropped lookup not answered", resp_cnt - p0, 0);
  endtask

  initial begin
    checks = 0; fails = 0;
    rd_cnt = 0; wr_cnt = 0; ord_err = 0; resp_cnt = 0;
    poke_en = 1'b0; poke_a = '0; poke_d = '0;
    lk_req = 1'b0; lk_idx = '0; csum_fix = 1'b0; ee_rdata = '0;
    rst_n = 1'b0;
    do_reset();
    t_reset();
    t_first_load();
    t_cached();
    t_out_of_range("R8");
    t_fix();
    t_bad_sum();
    t_bad_sig();
    build_image(4, 2'b01, 1'b0);
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule